// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every memory access a processor issues, whether the access may proceed or must raise a memory-management fault. Software programs a small set of protection regions through a word-addressed register port. Each region has a power-of-two size, a base aligned to that size, eight subregions that can be switched off one by one, an access-permission code, an execute-never flag and a six-bit memory-attribute field. A control register turns checking on, chooses whether checking stays on inside high-priority fault handlers, and can open a default background map to privileged code.

Each access carries an address, a kind (read, write or instruction fetch), a privilege flag and a flag that marks execution in a high-priority fault handler. One cycle later the block returns the verdict, whether an enabled region matched, which region won, and that region's attribute field. When regions overlap, the one with the highest number wins.

Top module: `prot_region_checker`

## Requirements
- R1: After reset the control word, the region-select word and every region's base and attribute words read as zero, and every access is allowed with no region hit.
- R2: While the global enable (control bit 0) is 0, every access is allowed and reports no hit, region 0 and attribute 0.
- R3: A region of size code N (N from 4 to 31) covers 2^(N+1) bytes from its base; base bits below the region size are ignored for matching, and base bits 4..0 always read back as 0.
- R4: A region with size code 31 covers the whole 32-bit address space whatever its base field holds.
- R5: Attribute bits 15..8 disable subregions 0..7, each one eighth of the region in ascending address order; an access in a disabled subregion does not match that region and falls through to lower regions or the miss rule. For size codes below 7 these bits are ignored.
- R6: With the execute-never bit (attribute bit 28) set, a fetch (kind 2) that hits the region faults; reads (kind 0) and writes (kind 1) follow only the permission code. With the bit clear, a fetch is judged as a read. Kind 3 is judged as a read.
- R7: The permission code (attribute bits 26..24) gives: 0 and 4 no access; 1 privileged read/write only; 2 privileged read/write, unprivileged read; 3 full access; 5 privileged read only; 6 and 7 read only for all.
- R8: A region whose enable bit (attribute bit 0) is 0, or whose size code (attribute bits 5..1) is below 4, never matches.
- R9: When several enabled regions match, the highest-numbered one supplies the verdict, the reported region number and the attribute field (attribute bits 21..16).
- R10: When checking is active and no region matches, a privileged access is allowed only if the background bit (control bit 2) is 1; an unprivileged access always faults.
- R11: With the handler bit (control bit 1) at 0, an access flagged as high-priority handler is allowed with no hit even when checking is on; with it at 1 such accesses are checked normally.
- R12: Registers sit at byte offsets 0x94 (control, bits 2..0), 0x98 (region select, low log2(NUM_REGIONS) bits), 0x9C (base of the selected region) and 0xA0 (attribute word of the selected region); unused bits read as zero and other offsets read as zero.
- R13: The response appears, with the valid flag high for exactly one cycle, on the clock edge after the access is presented.
- R14: With NUM_REGIONS set to 16, regions 8 to 15 are programmable and take part in matching and priority like the lower eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_offs | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_offs (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_priv | input | 1 | Access is privileged |
| acc_hipri | input | 1 | Access is made inside a high-priority fault handler |
| resp_valid | output | 1 | Verdict valid |
| resp_fault | output | 1 | Access must fault |
| resp_hit | output | 1 | An enabled region matched |
| resp_region | output | 4 | Number of the winning region |
| resp_attr | output | 6 | Attribute field of the winning region |

## Verification
The bench builds the checker with NUM_REGIONS at 16, which widens region select to four bits and makes regions 8 to 15 reachable, so priority between a region above 7 and one below it, and the select-field mask on readback, can both be exercised. The default of eight regions is covered by elaboration only. All other behaviour (subregion fall-through, full-map regions, the permission table and the handler and background rules) does not depend on the region count and is reached at 16.

// File: rtl/prc_pkg.sv
package prc_pkg;

    localparam int ADDR_W      = 32;
    localparam int DATA_W      = 32;
    localparam int MATTR_W     = 6;
    localparam int SRD_W       = 8;
    localparam int SIZE_W      = 5;
    localparam int AP_W        = 3;
    localparam int REGION_ID_W = 4;
    localparam int BASE_LSB    = 5;

    localparam logic [7:0] OFF_CTRL = 8'h94;
    localparam logic [7:0] OFF_RSEL = 8'h98;
    localparam logic [7:0] OFF_BASE = 8'h9C;
    localparam logic [7:0] OFF_ATTR = 8'hA0;

    localparam logic [SIZE_W-1:0] SIZE_MIN     = 5'd4;
    localparam logic [SIZE_W-1:0] SIZE_SUB_MIN = 5'd7;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic priv_dflt;
        logic hnd_en;
        logic glb_en;
    } ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:BASE_LSB] base_hi;
        logic                     xn;
        logic [AP_W-1:0]          ap;
        logic [MATTR_W-1:0]       mattr;
        logic [SRD_W-1:0]         srd;
        logic [SIZE_W-1:0]        size;
        logic                     en;
    } region_cfg_t;

    function automatic logic [DATA_W-1:0] pack_attr(input region_cfg_t r);
        logic [DATA_W-1:0] w;
        w         = '0;
        w[0]      = r.en;
        w[5:1]    = r.size;
        w[15:8]   = r.srd;
        w[21:16]  = r.mattr;
        w[26:24]  = r.ap;
        w[28]     = r.xn;
        return w;
    endfunction

    function automatic logic ap_permits(input logic [AP_W-1:0] ap,
                                        input logic [1:0] kind,
                                        input logic priv);
        logic rd;
        logic wr;
        case (ap)
            3'd1:    begin rd = priv;  wr = priv;  end
            3'd2:    begin rd = 1'b1;  wr = priv;  end
            3'd3:    begin rd = 1'b1;  wr = 1'b1;  end
            3'd5:    begin rd = priv;  wr = 1'b0;  end
            3'd6,
            3'd7:    begin rd = 1'b1;  wr = 1'b0;  end
            default: begin rd = 1'b0;  wr = 1'b0;  end
        endcase
        return (acc_kind_e'(kind) == ACC_WRITE) ? wr : rd;
    endfunction

endpackage

// File: rtl/prc_cfg_regs.sv
module prc_cfg_regs
    import prc_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [7:0]                         cfg_offs,
    input  logic [DATA_W-1:0]                  cfg_wdata,
    output logic [DATA_W-1:0]                  cfg_rdata,
    output ctrl_t                              ctrl_o,
    output region_cfg_t [NUM_REGIONS-1:0]      regions_o
);

    localparam int SEL_W = $clog2(NUM_REGIONS);

    ctrl_t            ctrl_q;
    logic [SEL_W-1:0] rsel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            rsel_q <= '0;
        end else if (cfg_we) begin
            if (cfg_offs == OFF_CTRL) ctrl_q <= ctrl_t'(cfg_wdata[2:0]);
            if (cfg_offs == OFF_RSEL) rsel_q <= cfg_wdata[SEL_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        region_cfg_t r_q;
        logic        sel_here;
        assign sel_here = cfg_we && (rsel_q == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (sel_here) begin
                if (cfg_offs == OFF_BASE) begin
                    r_q.base_hi <= cfg_wdata[ADDR_W-1:BASE_LSB];
                end
                if (cfg_offs == OFF_ATTR) begin
                    r_q.en    <= cfg_wdata[0];
                    r_q.size  <= cfg_wdata[5:1];
                    r_q.srd   <= cfg_wdata[15:8];
                    r_q.mattr <= cfg_wdata[21:16];
                    r_q.ap    <= cfg_wdata[26:24];
                    r_q.xn    <= cfg_wdata[28];
                end
            end
        end
        assign regions_o[g] = r_q;
    end

    always_comb begin
        case (cfg_offs)
            OFF_CTRL: cfg_rdata = DATA_W'(ctrl_q);
            OFF_RSEL: cfg_rdata = DATA_W'(rsel_q);
            OFF_BASE: cfg_rdata = {regions_o[rsel_q].base_hi, {BASE_LSB{1'b0}}};
            OFF_ATTR: cfg_rdata = pack_attr(regions_o[rsel_q]);
            default:  cfg_rdata = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_offs == OFF_CTRL) |=> (ctrl_o == ctrl_t'($past(cfg_wdata[2:0])))) // R12
        else $error("control write not captured");

endmodule

// File: rtl/prc_region_match.sv
module prc_region_match
    import prc_pkg::*;
(
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     en,
    input  logic [SIZE_W-1:0]        size,
    input  logic [SRD_W-1:0]         srd,
    input  logic [ADDR_W-1:BASE_LSB] base_hi,
    output logic                     hit
);

    logic [ADDR_W:0]   span;
    logic [ADDR_W-1:0] low_mask;
    logic [ADDR_W-1:0] base_full;
    logic [ADDR_W-1:0] sub_shift;
    logic [2:0]        sub_idx;
    logic              in_range;
    logic              sub_off;
    logic [SIZE_W:0]   size_log2;

    always_comb begin
        size_log2 = {1'b0, size} + 6'd1;
        span      = ({{ADDR_W{1'b0}}, 1'b1} << size_log2) - 33'd1;
        low_mask  = span[ADDR_W-1:0];
        base_full = {base_hi, {BASE_LSB{1'b0}}};
        in_range  = ((addr ^ base_full) & ~low_mask) == '0;
        sub_shift = addr >> (size - 5'd2);
        sub_idx   = sub_shift[2:0];
        sub_off   = (size >= SIZE_SUB_MIN) && srd[sub_idx];
        hit       = en && (size >= SIZE_MIN) && in_range && !sub_off;
    end

endmodule

// File: rtl/prc_resolve.sv
module prc_resolve
    import prc_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic [NUM_REGIONS-1:0]              hits,
    input  logic [NUM_REGIONS-1:0][AP_W-1:0]    ap_vec,
    input  logic [NUM_REGIONS-1:0]              xn_vec,
    input  logic [NUM_REGIONS-1:0][MATTR_W-1:0] mattr_vec,
    output logic                                any_hit,
    output logic [REGION_ID_W-1:0]              win_id,
    output logic [AP_W-1:0]                     win_ap,
    output logic                                win_xn,
    output logic [MATTR_W-1:0]                  win_mattr
);

    always_comb begin
        any_hit   = 1'b0;
        win_id    = '0;
        win_ap    = '0;
        win_xn    = 1'b0;
        win_mattr = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                any_hit   = 1'b1;
                win_id    = REGION_ID_W'(i);
                win_ap    = ap_vec[i];
                win_xn    = xn_vec[i];
                win_mattr = mattr_vec[i];
            end
        end
    end

endmodule

// File: rtl/prot_region_checker.sv
module prot_region_checker
    import prc_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [7:0]             cfg_offs,
    input  logic [DATA_W-1:0]      cfg_wdata,
    output logic [DATA_W-1:0]      cfg_rdata,
    input  logic                   acc_valid,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [1:0]             acc_kind,
    input  logic                   acc_priv,
    input  logic                   acc_hipri,
    output logic                   resp_valid,
    output logic                   resp_fault,
    output logic                   resp_hit,
    output logic [REGION_ID_W-1:0] resp_region,
    output logic [MATTR_W-1:0]     resp_attr
);

    ctrl_t                              ctrl;
    region_cfg_t [NUM_REGIONS-1:0]      regions;
    logic [NUM_REGIONS-1:0]             hits;
    logic [NUM_REGIONS-1:0][AP_W-1:0]   ap_vec;
    logic [NUM_REGIONS-1:0]             xn_vec;
    logic [NUM_REGIONS-1:0][MATTR_W-1:0] mattr_vec;

    logic                   any_hit;
    logic [REGION_ID_W-1:0] win_id;
    logic [AP_W-1:0]        win_ap;
    logic                   win_xn;
    logic [MATTR_W-1:0]     win_mattr;

    prc_cfg_regs #(.NUM_REGIONS(NUM_REGIONS)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_offs  (cfg_offs),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctrl_o    (ctrl),
        .regions_o (regions)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        prc_region_match i_match (
            .addr    (acc_addr),
            .en      (regions[g].en),
            .size    (regions[g].size),
            .srd     (regions[g].srd),
            .base_hi (regions[g].base_hi),
            .hit     (hits[g])
        );
        assign ap_vec[g]    = regions[g].ap;
        assign xn_vec[g]    = regions[g].xn;
        assign mattr_vec[g] = regions[g].mattr;
    end

    prc_resolve #(.NUM_REGIONS(NUM_REGIONS)) i_resolve (
        .hits      (hits),
        .ap_vec    (ap_vec),
        .xn_vec    (xn_vec),
        .mattr_vec (mattr_vec),
        .any_hit   (any_hit),
        .win_id    (win_id),
        .win_ap    (win_ap),
        .win_xn    (win_xn),
        .win_mattr (win_mattr)
    );

    logic                   bypass;
    logic                   fault_c;
    logic                   hit_c;
    logic [REGION_ID_W-1:0] id_c;
    logic [MATTR_W-1:0]     attr_c;

    always_comb begin
        bypass  = !ctrl.glb_en || (acc_hipri && !ctrl.hnd_en);
        fault_c = 1'b0;
        hit_c   = 1'b0;
        id_c    = '0;
        attr_c  = '0;
        if (!bypass) begin
            if (any_hit) begin
                hit_c   = 1'b1;
                id_c    = win_id;
                attr_c  = win_mattr;
                if (acc_kind_e'(acc_kind) == ACC_FETCH && win_xn) fault_c = 1'b1;
                else fault_c = !ap_permits(win_ap, acc_kind, acc_priv);
            end else begin
                fault_c = !(acc_priv && ctrl.priv_dflt);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid  <= 1'b0;
            resp_fault  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_region <= '0;
            resp_attr   <= '0;
        end else begin
            resp_valid <= acc_valid;
            if (acc_valid) begin
                resp_fault  <= fault_c;
                resp_hit    <= hit_c;
                resp_region <= id_c;
                resp_attr   <= attr_c;
            end
        end
    end

    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> resp_valid) // R13
        else $error("missing response");

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !resp_valid) // R13
        else $error("spurious response");

    AST_GLOBAL_OFF_ALLOWS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !ctrl.glb_en) |=> (!resp_fault && !resp_hit)) // R2
        else $error("fault while checking disabled");

    AST_HANDLER_BYPASS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_hipri && !ctrl.hnd_en) |=> (!resp_fault && !resp_hit)) // R11
        else $error("handler access checked");

    AST_UNPRIV_MISS: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !bypass && !any_hit && !acc_priv) |=> (resp_fault && !resp_hit)) // R10
        else $error("unprivileged miss allowed");

    AST_XN_FETCH: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !bypass && any_hit && win_xn && acc_kind == 2'd2) |=> resp_fault) // R6
        else $error("fetch from execute-never region allowed");

endmodule

// File: tb/test_prot_region_checker.sv
module test_prot_region_checker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_offs = 8'h00;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic [1:0]  acc_kind = 2'd0;
    logic        acc_priv = 1'b0;
    logic        acc_hipri = 1'b0;
    logic        resp_valid;
    logic        resp_fault;
    logic        resp_hit;
    logic [3:0]  resp_region;
    logic [5:0]  resp_attr;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    prot_region_checker #(.NUM_REGIONS(16)) i_prot_region_checker (
        .clk, .rst, .cfg_we, .cfg_offs, .cfg_wdata, .cfg_rdata,
        .acc_valid, .acc_addr, .acc_kind, .acc_priv, .acc_hipri,
        .resp_valid, .resp_fault, .resp_hit, .resp_region, .resp_attr
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_attr(input logic en, input logic [4:0] size,
                                            input logic [7:0] srd, input logic [5:0] ma,
                                            input logic [2:0] ap, input logic xn);
        return {3'b0, xn, 1'b0, ap, 2'b0, ma, srd, 2'b0, size, en};
    endfunction

    task automatic wr(input logic [7:0] offs, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_offs = offs; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] offs, output logic [31:0] data);
        @(negedge clk);
        cfg_offs = offs;
        #1 data = cfg_rdata;
    endtask

    task automatic set_region(input int idx, input logic [31:0] base, input logic [31:0] attr);
        wr(8'h98, 32'(idx));
        wr(8'h9C, base);
        wr(8'hA0, attr);
    endtask

    task automatic clear_all();
        for (int i = 0; i < 16; i++) set_region(i, 32'h0, 32'h0);
    endtask

    // control: bit0 enable, bit1 handler, bit2 background
    task automatic set_ctrl(input logic en, input logic hnd, input logic bg);
        wr(8'h94, {29'b0, bg, hnd, en});
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] k, input logic p, input logic h);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_kind = k; acc_priv = p; acc_hipri = h;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic expect_acc(input string req, input logic f, input logic h, input logic [3:0] r);
        chk(req, {25'b0, resp_valid, resp_fault, resp_hit, resp_region},
                 {25'b0, 1'b1, f, h, r});
    endtask

    function automatic logic perm(input logic [2:0] ap, input logic wr_acc, input logic p);
        logic r, w;
        r = (ap == 3'd3) || (ap == 3'd2) || (ap >= 3'd6) || (p && (ap == 3'd1 || ap == 3'd5));
        w = (ap == 3'd3) || (p && (ap == 3'd1 || ap == 3'd2));
        return wr_acc ? w : r;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h94, d); chk("R1 ctrl", d, 32'h0);
        rd(8'h98, d); chk("R1 rsel", d, 32'h0);
        rd(8'hA0, d); chk("R1 attr", d, 32'h0);
        rd(8'h9C, d); chk("R1 base", d, 32'h0);
        access(32'h2000_0000, 2'd1, 1'b0, 1'b0);
        expect_acc("R1 access", 1'b0, 1'b0, 4'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(8'h98, 32'h1F); rd(8'h98, d); chk("R12 rsel mask", d, 32'hF);
        wr(8'h94, 32'hFFFF_FFFF); rd(8'h94, d); chk("R12 ctrl mask", d, 32'h7);
        wr(8'h98, 32'h3);
        wr(8'h9C, 32'h1234_5678); rd(8'h9C, d); chk("R3 base low bits", d, 32'h1234_5660);
        wr(8'hA0, 32'hFFFF_FFFF); rd(8'hA0, d); chk("R12 attr mask", d, 32'h173F_FF3F);
        rd(8'h50, d); chk("R12 unmapped", d, 32'h0);
        set_ctrl(1'b0, 1'b0, 1'b0);
        clear_all();
    endtask

    task automatic t_global();
        set_region(0, 32'h0, mk_attr(1, 5'd9, 8'h0, 6'h0, 3'd0, 0));
        set_ctrl(1'b0, 1'b0, 1'b0);
        access(32'h100, 2'd0, 1'b0, 1'b0);
        expect_acc("R2 off allows", 1'b0, 1'b0, 4'd0);
        chk("R2 attr zero", 32'(resp_attr), 32'h0);
        set_ctrl(1'b1, 1'b0, 1'b0);
        access(32'h100, 2'd0, 1'b0, 1'b0);
        expect_acc("R2 on checks", 1'b1, 1'b1, 4'd0);
    endtask

    task automatic t_ap_table();
        for (int ap = 0; ap < 8; ap++) begin
            set_region(0, 32'h0, mk_attr(1, 5'd9, 8'h0, 6'h0, 3'(ap), 0));
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < 2; k++) begin
                    access(32'h100, 2'(k), 1'(p), 1'b0);
                    expect_acc($sformatf("R7 ap=%0d priv=%0d kind=%0d", ap, p, k),
                               !perm(3'(ap), 1'(k), 1'(p)), 1'b1, 4'd0);
                end
            end
        end
    endtask

    task automatic t_xn();
        set_region(0, 32'h0, mk_attr(1, 5'd9, 8'h0, 6'h0, 3'd3, 1));
        access(32'h40, 2'd2, 1'b1, 1'b0); expect_acc("R6 xn fetch", 1'b1, 1'b1, 4'd0);
        access(32'h40, 2'd0, 1'b0, 1'b0); expect_acc("R6 xn read", 1'b0, 1'b1, 4'd0);
        access(32'h40, 2'd1, 1'b0, 1'b0); expect_acc("R6 xn write", 1'b0, 1'b1, 4'd0);
        set_region(0, 32'h0, mk_attr(1, 5'd9, 8'h0, 6'h0, 3'd2, 0));
        access(32'h40, 2'd2, 1'b0, 1'b0); expect_acc("R6 fetch as read", 1'b0, 1'b1, 4'd0);
        access(32'h40, 2'd3, 1'b0, 1'b0); expect_acc("R6 kind3 as read", 1'b0, 1'b1, 4'd0);
        set_region(0, 32'h0, mk_attr(1, 5'd9, 8'h0, 6'h0, 3'd1, 0));
        access(32'h40, 2'd2, 1'b0, 1'b0); expect_acc("R6 fetch unpriv denied", 1'b1, 1'b1, 4'd0);
        clear_all();
    endtask

    task automatic t_align();
        set_region(1, 32'h0001_0ABC, mk_attr(1, 5'd15, 8'h0, 6'h0, 3'd3, 0));
        access(32'h0001_0000, 2'd0, 1'b0, 1'b0); expect_acc("R3 first byte", 1'b0, 1'b1, 4'd1);
        access(32'h0001_FFFC, 2'd0, 1'b0, 1'b0); expect_acc("R3 last word", 1'b0, 1'b1, 4'd1);
        access(32'h0002_0000, 2'd0, 1'b0, 1'b0); expect_acc("R3 above", 1'b1, 1'b0, 4'd0);
        access(32'h0000_FFFC, 2'd0, 1'b0, 1'b0); expect_acc("R3 below", 1'b1, 1'b0, 4'd0);
        clear_all();
    endtask

    task automatic t_full();
        set_region(2, 32'h8000_0000, mk_attr(1, 5'd31, 8'h0, 6'h0, 3'd3, 0));
        access(32'h0000_0010, 2'd1, 1'b0, 1'b0); expect_acc("R4 low addr", 1'b0, 1'b1, 4'd2);
        access(32'hFFFF_FFF0, 2'd1, 1'b0, 1'b0); expect_acc("R4 high addr", 1'b0, 1'b1, 4'd2);
        clear_all();
    endtask

    task automatic t_subregion();
        set_region(3, 32'h2000_0000, mk_attr(1, 5'd11, 8'h0, 6'h0, 3'd6, 0));
        set_region(4, 32'h2000_0000, mk_attr(1, 5'd10, 8'h04, 6'h0, 3'd3, 0));
        access(32'h2000_0150, 2'd1, 1'b0, 1'b0); expect_acc("R5 enabled sub", 1'b0, 1'b1, 4'd4);
        access(32'h2000_0250, 2'd1, 1'b0, 1'b0); expect_acc("R5 disabled sub write", 1'b1, 1'b1, 4'd3);
        access(32'h2000_0250, 2'd0, 1'b0, 1'b0); expect_acc("R5 disabled sub read", 1'b0, 1'b1, 4'd3);
        set_region(5, 32'h3000_0000, mk_attr(1, 5'd6, 8'hFF, 6'h0, 3'd3, 0));
        access(32'h3000_0040, 2'd0, 1'b0, 1'b0); expect_acc("R5 small region ignores srd", 1'b0, 1'b1, 4'd5);
        clear_all();
    endtask

    task automatic t_disabled();
        set_region(6, 32'h0, mk_attr(1, 5'd3, 8'h0, 6'h0, 3'd3, 0));
        access(32'h4, 2'd0, 1'b0, 1'b0); expect_acc("R8 reserved size", 1'b1, 1'b0, 4'd0);
        set_region(6, 32'h0, mk_attr(0, 5'd9, 8'h0, 6'h0, 3'd3, 0));
        access(32'h4, 2'd0, 1'b0, 1'b0); expect_acc("R8 enable off", 1'b1, 1'b0, 4'd0);
        clear_all();
    endtask

    task automatic t_overlap();
        set_region(2, 32'h4000_0000, mk_attr(1, 5'd12, 8'h0, 6'h11, 3'd3, 0));
        set_region(7, 32'h4000_0000, mk_attr(1, 5'd12, 8'h0, 6'h22, 3'd0, 0));
        access(32'h4000_0100, 2'd0, 1'b0, 1'b0); expect_acc("R9 higher wins", 1'b1, 1'b1, 4'd7);
        chk("R9 attr of winner", 32'(resp_attr), 32'h22);
        set_region(7, 32'h4000_0000, 32'h0);
        access(32'h4000_0100, 2'd0, 1'b0, 1'b0); expect_acc("R9 lower after disable", 1'b0, 1'b1, 4'd2);
        chk("R9 attr lower", 32'(resp_attr), 32'h11);
        clear_all();
    endtask

    task automatic t_wide();
        set_region(8,  32'h5000_0000, mk_attr(1, 5'd9, 8'h0, 6'h2A, 3'd3, 0));
        access(32'h5000_0010, 2'd1, 1'b0, 1'b0); expect_acc("R14 region 8", 1'b0, 1'b1, 4'd8);
        set_region(15, 32'h5000_0000, mk_attr(1, 5'd9, 8'h0, 6'h15, 3'd0, 0));
        access(32'h5000_0010, 2'd1, 1'b0, 1'b0); expect_acc("R14 region 15 wins", 1'b1, 1'b1, 4'd15);
        chk("R14 attr", 32'(resp_attr), 32'h15);
        clear_all();
    endtask

    task automatic t_miss();
        set_ctrl(1'b1, 1'b0, 1'b1);
        access(32'h6000_0000, 2'd0, 1'b1, 1'b0); expect_acc("R10 priv background", 1'b0, 1'b0, 4'd0);
        access(32'h6000_0000, 2'd0, 1'b0, 1'b0); expect_acc("R10 unpriv miss", 1'b1, 1'b0, 4'd0);
        set_ctrl(1'b1, 1'b0, 1'b0);
        access(32'h6000_0000, 2'd0, 1'b1, 1'b0); expect_acc("R10 priv no background", 1'b1, 1'b0, 4'd0);
    endtask

    task automatic t_handler();
        set_region(0, 32'h0, mk_attr(1, 5'd9, 8'h0, 6'h0, 3'd0, 0));
        set_ctrl(1'b1, 1'b0, 1'b0);
        access(32'h10, 2'd0, 1'b1, 1'b1); expect_acc("R11 handler bypass", 1'b0, 1'b0, 4'd0);
        access(32'h10, 2'd0, 1'b1, 1'b0); expect_acc("R11 normal checked", 1'b1, 1'b1, 4'd0);
        set_ctrl(1'b1, 1'b1, 1'b0);
        access(32'h10, 2'd0, 1'b1, 1'b1); expect_acc("R11 handler checked", 1'b1, 1'b1, 4'd0);
        set_ctrl(1'b1, 1'b0, 1'b0);
        clear_all();
    endtask

    task automatic t_timing();
        access(32'h10, 2'd0, 1'b1, 1'b0);
        chk("R13 valid after one edge", 32'(resp_valid), 32'h1);
        @(negedge clk);
        chk("R13 single pulse", 32'(resp_valid), 32'h0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_global();
        t_ap_table();
        t_xn();
        t_align();
        t_full();
        t_subregion();
        t_disabled();
        t_overlap();
        t_wide();
        t_miss();
        t_handler();
        t_timing();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule